// File: doc/BRIEF.md
# PWM-Synchronised Modulator Clock Starter

This block makes the bit clock for an external sigma-delta modulator by dividing the system clock by an integer ratio. After reset, or after the block is re-armed, the clock is held low. A rising edge on the PWM sync input starts a down-counter loaded with half the length of the sinc filter's impulse response, measured in system clocks. When that count expires the divider starts. The first modulator clock edge then comes half an impulse response after the sync. With the stream starting at that point, the centre of the sinc filter's impulse response lines up with the PWM average-current instant.

The alignment is done once. After the clock starts it runs freely, and further sync pulses have no effect. The system stays in step because the modulator rate is an integer multiple of the PWM rate. A one-cycle arm input stops the clock and returns the block to waiting for the next sync edge.

The control is a three-state machine:

- WAIT: armed, clock stopped.
- DELAY: counting down the alignment delay.
- RUN: clock toggling.

The transitions are:

- WAIT to DELAY: on a sync rising edge when the computed delay is nonzero.
- WAIT to RUN: on a sync rising edge when the computed delay is zero.
- DELAY to RUN: when the count expires.
- DELAY to WAIT and RUN to WAIT: on arm.
- WAIT to WAIT: on arm. A WAIT state with arm high ignores a sync edge in the same cycle.

Top module: `mod_clk_starter`

## Requirements
- R1: During reset and in the first cycle after it, `running`, `mclk_out` and `mclk_en` are 0.
- R2: While `running` is 0, `mclk_out` and `mclk_en` stay 0, and with no sync rising edge the block stays stopped.
- R3: If a `pwm_sync` rising edge is sampled at clock edge E, `running` first reads 1 after clock edge E+N. Here N = floor(M*(O*D-2)/2), where O is `filt_order`, D is `dec_rate` and M is the effective divide ratio. N = 0 when O*D < 2. The effective divide ratio M is `mdiv`, with values below 2 treated as 2.
- R4: In the cycle where `running` first reads 1, `mclk_out` and `mclk_en` are both 1.
- R5: While running, take cycle index i counted from the start cycle (i = 0). `mclk_en` is 1 exactly when i mod M = 0. `mclk_out` is 1 exactly when (i mod M) < floor(M/2), which gives a 50% duty cycle for even M.
- R6: A sync rising edge during DELAY does not change when the clock starts. A sync rising edge during RUN does not disturb the clock phase.
- R7: When `arm` is sampled high, `running`, `mclk_out` and `mclk_en` read 0 after that edge. The next sync rising edge then restarts the block with the R3 delay.
- R8: `arm` has priority over a sync rising edge in the same cycle, and that edge is discarded. If sync is held high through the arm, it does not start the block.
- R9: Only a rising edge of `pwm_sync` starts the block. Holding it high starts it once, and the clock is not disturbed while it stays high.
- R10: M is captured at the start cycle. Changing `mdiv` while running does not change the clock period.
- R11: O, D and M are sampled at the sync edge. Changing them during DELAY does not change the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Stop the clock and wait for the next sync edge |
| pwm_sync | input | 1 | PWM synchronising pulse, rising edge used |
| mdiv | input | MDIV_W | System clocks per modulator clock period |
| filt_order | input | ORD_W | Sinc filter order O |
| dec_rate | input | DEC_W | Sinc filter decimation rate D |
| mclk_out | output | 1 | Modulator clock |
| mclk_en | output | 1 | One-cycle strobe coinciding with each modulator clock rise |
| running | output | 1 | Modulator clock is toggling |

## Verification
A wrong delay count or a wrong state shows up as `running` rising one or more cycles away from the N predicted for each tested ratio, order and rate. A wrong state can also show as the block refusing to stop or restart after arm. A wrong divider phase or a wrong captured ratio shows within one modulator period as a misplaced `mclk_en` strobe or a wrong high time of `mclk_out`. An error in edge detection or in the priority between arm and sync shows within a few cycles as a start that should not happen, or as a delay that restarts and lands late.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2
    } mcs_state_e;

endpackage

// File: rtl/mcs_sync_edge.sv
module mcs_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic sync_rise
);

    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_in;
    end

    assign sync_rise = sync_in & ~sync_q;

endmodule

// File: rtl/mcs_delay_calc.sv
module mcs_delay_calc #(
    parameter int MDIV_W = 8,
    parameter int ORD_W  = 3,
    parameter int DEC_W  = 9,
    localparam int OD_W  = ORD_W + DEC_W,
    localparam int CNT_W = MDIV_W + OD_W
) (
    input  logic [MDIV_W-1:0] mdiv_eff,
    input  logic [ORD_W-1:0]  filt_order,
    input  logic [DEC_W-1:0]  dec_rate,
    output logic [CNT_W-1:0]  delay_val
);

    logic [OD_W-1:0]  od;
    logic [OD_W-1:0]  span;
    logic [CNT_W-1:0] prod;

    always_comb begin
        od        = OD_W'(filt_order) * OD_W'(dec_rate);
        span      = (od < OD_W'(2)) ? '0 : od - OD_W'(2);
        prod      = CNT_W'(mdiv_eff) * CNT_W'(span);
        delay_val = prod >> 1;
    end

endmodule

// File: rtl/mcs_fsm.sv
module mcs_fsm
    import mcs_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             sync_rise,
    input  logic [CNT_W-1:0] delay_val,
    output logic             running,
    output logic             run_start,
    output logic             run_next
);

    mcs_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_WAIT: begin
                if (!arm && sync_rise) begin
                    if (delay_val == '0) begin
                        state_n = ST_RUN;
                    end else begin
                        state_n = ST_DELAY;
                        cnt_n   = delay_val;
                    end
                end
            end
            ST_DELAY: begin
                if (arm)                         state_n = ST_WAIT;
                else if (cnt <= CNT_W'(1))       state_n = ST_RUN;
                else                             cnt_n   = cnt - CNT_W'(1);
            end
            ST_RUN: begin
                if (arm) state_n = ST_WAIT;
            end
            default: state_n = ST_WAIT;
        endcase
    end

    always_comb begin
        running   = (state == ST_RUN);
        run_next  = (state_n == ST_RUN);
        run_start = (state != ST_RUN) && (state_n == ST_RUN);
    end

    assert_delay_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && !arm && cnt > CNT_W'(1)) |=> (state == ST_DELAY && cnt == $past(cnt) - CNT_W'(1)));

    assert_run_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !arm) |=> (state == ST_RUN));

    assert_arm_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (state == ST_WAIT));

    assert_arm_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && arm && sync_rise) |=> (state == ST_WAIT));

endmodule

// File: rtl/mcs_clk_div.sv
module mcs_clk_div #(
    parameter int MDIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_start,
    input  logic              run_next,
    input  logic [MDIV_W-1:0] mdiv_eff,
    output logic              mclk,
    output logic              mclk_en
);

    logic [MDIV_W-1:0] ph, ph_n, m_q;

    always_comb begin
        ph_n = (ph >= m_q - MDIV_W'(1)) ? '0 : ph + MDIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= '0;
            m_q     <= MDIV_W'(2);
            mclk    <= 1'b0;
            mclk_en <= 1'b0;
        end else if (!run_next) begin
            ph      <= '0;
            mclk    <= 1'b0;
            mclk_en <= 1'b0;
        end else if (run_start) begin
            ph      <= '0;
            m_q     <= mdiv_eff;
            mclk    <= 1'b1;
            mclk_en <= 1'b1;
        end else begin
            ph      <= ph_n;
            mclk    <= (ph_n < (m_q >> 1));
            mclk_en <= (ph_n == '0);
        end
    end

    assert_en_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en |-> (mclk && !$past(mclk)));

    assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ph < m_q);

    assert_period_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_next && !run_start) |=> $stable(m_q));

endmodule

// File: rtl/mod_clk_starter.sv
module mod_clk_starter #(
    parameter int MDIV_W = 8,
    parameter int ORD_W  = 3,
    parameter int DEC_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              pwm_sync,
    input  logic [MDIV_W-1:0] mdiv,
    input  logic [ORD_W-1:0]  filt_order,
    input  logic [DEC_W-1:0]  dec_rate,
    output logic              mclk_out,
    output logic              mclk_en,
    output logic              running
);

    localparam int CNT_W = MDIV_W + ORD_W + DEC_W;

    logic              sync_rise;
    logic              run_start;
    logic              run_next;
    logic [MDIV_W-1:0] mdiv_eff;
    logic [CNT_W-1:0]  delay_val;

    assign mdiv_eff = (mdiv < MDIV_W'(2)) ? MDIV_W'(2) : mdiv;

    mcs_sync_edge i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (pwm_sync),
        .sync_rise (sync_rise)
    );

    mcs_delay_calc #(
        .MDIV_W (MDIV_W),
        .ORD_W  (ORD_W),
        .DEC_W  (DEC_W)
    ) i_calc (
        .mdiv_eff   (mdiv_eff),
        .filt_order (filt_order),
        .dec_rate   (dec_rate),
        .delay_val  (delay_val)
    );

    mcs_fsm #(
        .CNT_W (CNT_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .sync_rise (sync_rise),
        .delay_val (delay_val),
        .running   (running),
        .run_start (run_start),
        .run_next  (run_next)
    );

    mcs_clk_div #(
        .MDIV_W (MDIV_W)
    ) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_start (run_start),
        .run_next  (run_next),
        .mdiv_eff  (mdiv_eff),
        .mclk      (mclk_out),
        .mclk_en   (mclk_en)
    );

    assert_quiet_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!mclk_out && !mclk_en));

endmodule

// File: tb/test_mod_clk_starter.sv
`timescale 1ns/1ps
module test_mod_clk_starter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic       pwm_sync = 1'b0;
    logic [7:0] mdiv = 8'd8;
    logic [2:0] filt_order = 3'd3;
    logic [8:0] dec_rate = 9'd5;
    logic       mclk_out, mclk_en, running;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mod_clk_starter i_mod_clk_starter (
        .clk(clk), .rst_n(rst_n), .arm(arm), .pwm_sync(pwm_sync),
        .mdiv(mdiv), .filt_order(filt_order), .dec_rate(dec_rate),
        .mclk_out(mclk_out), .mclk_en(mclk_en), .running(running)
    );

    localparam int NV = 7;
    localparam int VT_MDIV [NV] = '{8, 4, 3, 2, 5, 6, 1};
    localparam int VT_ORD  [NV] = '{3, 3, 2, 1, 3, 1, 1};
    localparam int VT_DEC  [NV] = '{5, 16, 3, 3, 3, 1, 4};
    localparam int VT_N    [NV] = '{52, 92, 6, 1, 17, 0, 2};
    localparam int VT_M    [NV] = '{8, 4, 3, 2, 5, 6, 2};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int m, input int o, input int d);
        mdiv       = 8'(m);
        filt_order = 3'(o);
        dec_rate   = 9'(d);
    endtask

    task automatic do_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    // leaves the bench at the negedge after the edge that sampled the rise (k = 0)
    task automatic fire_sync();
        @(negedge clk) pwm_sync = 1'b1;
        @(negedge clk) pwm_sync = 1'b0;
    endtask

    task automatic wait_run(input int pulse_at, output int k);
        k = 0;
        while (!running && k < 5000) begin
            pwm_sync = (k == pulse_at);
            @(negedge clk);
            k++;
        end
        pwm_sync = 1'b0;
    endtask

    task automatic check_wave(input int m, input int cycles, input bit pulse, input string req);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            int p = i % m;
            if (pulse) pwm_sync = (i == 0);
            if (mclk_en != (p == 0) || mclk_out != (p < m / 2) || !running) bad++;
            @(negedge clk);
        end
        if (pulse) pwm_sync = 1'b0;
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int k;
        int hi;
        // R1: reset state
        #1;
        chk(!running && !mclk_out && !mclk_en, "R1 during reset", int'(running), 0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!running && !mclk_out && !mclk_en, "R1 after reset", int'(mclk_out), 0);

        // R2: no sync means no clock
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (running || mclk_out || mclk_en) hi++;
        end
        chk(hi == 0, "R2 idle", hi, 0);

        // table of configurations: R3 delay, R4 first edge, R5 waveform
        for (int v = 0; v < NV; v++) begin
            do_arm();
            set_cfg(VT_MDIV[v], VT_ORD[v], VT_DEC[v]);
            chk(!running && !mclk_out, "R7 stopped after arm", int'(running), 0);
            fire_sync();
            wait_run(-1, k);
            chk(k == VT_N[v], "R3 start delay", k, VT_N[v]);
            chk(mclk_out && mclk_en, "R4 first edge", int'(mclk_out) + 2 * int'(mclk_en), 3);
            check_wave(VT_M[v], 3 * VT_M[v], 1'b0, "R5 waveform");
        end

        // R6: sync during running leaves phase intact
        check_wave(2, 6, 1'b1, "R6 sync while running");

        // R7: arm while running stops at once, then restart
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
        chk(!running && !mclk_out && !mclk_en, "R7 arm stops", int'(running), 0);
        set_cfg(3, 2, 3);
        fire_sync();
        wait_run(-1, k);
        chk(k == 6, "R7 restart delay", k, 6);

        // R6 and R11: sync pulse during delay and parameter change during delay
        do_arm();
        set_cfg(4, 3, 4);
        fire_sync();
        set_cfg(4, 3, 16);
        wait_run(5, k);
        chk(k == 20, "R6 R11 delay unchanged", k, 20);

        // R10: mdiv change while running
        mdiv = 8'd6;
        check_wave(4, 12, 1'b0, "R10 period held");

        // R8: arm with simultaneous sync edge, sync held high afterwards
        set_cfg(2, 1, 1);
        @(negedge clk) begin arm = 1'b1; pwm_sync = 1'b1; end
        @(negedge clk) arm = 1'b0;
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            if (running) hi++;
            @(negedge clk);
        end
        chk(hi == 0, "R8 arm wins", hi, 0);
        pwm_sync = 1'b0;
        fire_sync();
        wait_run(-1, k);
        chk(k == 0, "R8 new edge starts", k, 0);

        // R9: sync held high starts once, clock undisturbed
        do_arm();
        set_cfg(3, 2, 3);
        @(negedge clk) pwm_sync = 1'b1;
        @(negedge clk);
        k = 0;
        while (!running && k < 5000) begin @(negedge clk); k++; end
        chk(k == 6, "R9 held sync delay", k, 6);
        begin
            int bad = 0;
            for (int i = 0; i < 9; i++) begin
                if (mclk_en != (i % 3 == 0) || mclk_out != (i % 3 < 1)) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R9 held sync waveform", bad, 0);
        end
        pwm_sync = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule